// File: doc/BRIEF.md
# Power and Sleep Domain Controller

This block holds the staged and applied power settings for a group of modules organised into domains. Software writes a requested module state into each module's control word and an on/off request into each domain's control word. None of these writes changes any output by itself. A write to the go register, one bit per domain, starts a fixed-length transition for every selected domain. While it runs, the domain's busy bit reads high. When it ends, every module of that domain takes the state staged in its control word, and the domain status takes the staged on/off request.

Each module drives a clock enable and an active-low local reset. The clock enable is high only in the enable state (code 3). In that state the local reset follows the software-written reset bit, and in every other state it is held asserted. Module `m` belongs to domain `m / MODS_PER_DOM`. A domain that is off and has been asked to come on needs extra power-up cycles before its modules take their new states.

The bus is a 32-bit register port with a byte address, a write strobe, write data and combinational read data. Module and domain registers are spaced four bytes apart from their base offsets.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset, every status and control register reads 0, no busy bit is set, every `mod_clk_en` bit is 0 and every `mod_rst_n` bit is 0.
- R2: A module control word at 0xA00+4m keeps its requested state in bits [5:0], its local-reset bit in bit 8 and its force bit in bit 31, and all other bits read 0. Writing it leaves that module's status and clock enable unchanged until a go command completes.
- R3: The domain control word at 0x300+4d keeps its power-on request in bit 0. The domain status at 0x200+4d reads 1 in bits [4:0] when the domain is on and 0 when it is off.
- R4: Writing 1 at bit d of the go register (0x120) while domain d is idle sets bit d of the transition status (0x128). For a domain that is not powering up, that bit falls exactly XFER_CYCLES clock edges after the edge that took the go write.
- R5: When a domain's transition completes, the status bits [5:0] of each of its modules (0x800+4m) equal the state in that module's control bits [5:0]. The status of modules in other domains does not change.
- R6: If the domain is off and its control bit 0 is 1, the transition lasts XFER_CYCLES+PWRUP_CYCLES edges and the domain status becomes 1 at completion. If control bit 0 is 0, the domain status becomes 0 at completion.
- R7: A go bit written for a domain that is already busy is ignored, so the completion time of the running transition does not move.
- R8: Module status bit 12 and `mod_clk_en[m]` are 1 exactly when the module's applied state is 3 (enable).
- R9: `mod_rst_n[m]` equals module control bit 8 while the applied state is 3, and is 0 in every other state. It follows control bit 8 without waiting for a go.
- R10: The go register and every unmapped address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| mod_clk_en | output | N_DOM*MODS_PER_DOM | Per-module clock enable |
| mod_rst_n | output | N_DOM*MODS_PER_DOM | Per-module local reset, active low |

## Verification
A wrong transition counter shows at the ports as a busy bit that drops one or more cycles early or late. The bench catches this on the first poll after the drop, because it times every transition to the exact edge. A wrong applied state, or a module wired to the wrong domain, shows in the module status word and in the clock-enable and reset pins as soon as the transition completes. The bench sweeps every pair of states for the two modules of each domain and rereads all four modules each time, so changes to modules in other domains are also seen. A stale domain-on flag shows as a transition that is too long or too short on the next go, and as a wrong domain status value.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int ADDR_W = 12;

    // Register map (byte offsets); software relies on these locations
    localparam logic [ADDR_W-1:0] OFF_GO    = 12'h120;
    localparam logic [ADDR_W-1:0] OFF_BUSY  = 12'h128;
    localparam logic [ADDR_W-1:0] OFF_DSTAT = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_DCTL  = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_MSTAT = 12'h800;
    localparam logic [ADDR_W-1:0] OFF_MCTL  = 12'hA00;

    localparam int ST_W = 6;
    // State codes: 0 soft-reset-off, 1 sync reset, 2 disabled, 3 enabled
    localparam logic [ST_W-1:0] ST_ENABLED = 6'd3;

    localparam int BIT_LRST  = 8;
    localparam int BIT_FORCE = 31;
    localparam int BIT_CLKON = 12;
endpackage

// File: rtl/pdc_domain_seq.sv
module pdc_domain_seq
    import pdc_pkg::*;
#(
    parameter int XFER_CYCLES  = 8,
    parameter int PWRUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_on,
    input  logic go,
    output logic busy,
    output logic done,
    output logic dom_on,
    output logic req_on
);
    localparam int CW = $clog2(XFER_CYCLES + PWRUP_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic          on;
        logic          req;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q, d;
    logic fin;

    always_comb begin
        d   = q;
        fin = q.busy && (q.cnt == CW'(1));
        if (ctl_we) d.req = ctl_on;
        if (fin) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.on   = q.req;
        end else if (q.busy) begin
            d.cnt = q.cnt - CW'(1);
        end else if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(XFER_CYCLES) +
                     ((!q.on && q.req) ? CW'(PWRUP_CYCLES) : CW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign done   = fin;
    assign dom_on = q.on;
    assign req_on = q.req;

    // R4: busy only ends when the countdown reaches its last cycle
    p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(q.cnt) == CW'(1));
    // R7: a running count keeps descending whatever go does
    p_retrigger_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt > CW'(1)) |=> (q.busy && q.cnt == $past(q.cnt) - CW'(1)));
    // R6: domain power flag changes only at a completion
    p_on_only_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(q.on));
endmodule

// File: rtl/pdc_module_slot.sv
module pdc_module_slot
    import pdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [ST_W-1:0] wd_state,
    input  logic            wd_lrst,
    input  logic            wd_force,
    input  logic            apply,
    output logic [31:0]     ctl_rd,
    output logic [31:0]     stat_rd,
    output logic            clk_en,
    output logic            lrst_n
);
    typedef struct packed {
        logic [ST_W-1:0] nxt;
        logic            lrst;
        logic            frc;
        logic [ST_W-1:0] cur;
    } slot_t;

    slot_t q, d;
    logic  is_en;

    always_comb begin
        d = q;
        if (ctl_we) begin
            d.nxt  = wd_state;
            d.lrst = wd_lrst;
            d.frc  = wd_force;
        end
        if (apply) d.cur = q.nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        is_en   = (q.cur == ST_ENABLED);
        ctl_rd  = '0;
        ctl_rd[ST_W-1:0]  = q.nxt;
        ctl_rd[BIT_LRST]  = q.lrst;
        ctl_rd[BIT_FORCE] = q.frc;
        stat_rd = '0;
        stat_rd[ST_W-1:0] = q.cur;
        stat_rd[BIT_CLKON] = is_en;
    end

    assign clk_en = is_en;
    assign lrst_n = is_en & q.lrst;

    // R5: applied state only moves on an apply, and then to the staged value
    p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(q.cur));
    p_state_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> q.cur == $past(q.nxt));
    // R9: local reset is released only while clock is enabled
    p_rst_needs_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lrst_n |-> clk_en);
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
    import pdc_pkg::*;
#(
    parameter int N_DOM        = 2,
    parameter int MODS_PER_DOM = 2,
    parameter int XFER_CYCLES  = 8,
    parameter int PWRUP_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [11:0]                   bus_addr,
    input  logic                          bus_we,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic [N_DOM*MODS_PER_DOM-1:0] mod_clk_en,
    output logic [N_DOM*MODS_PER_DOM-1:0] mod_rst_n
);
    localparam int N_MOD = N_DOM * MODS_PER_DOM;

    logic [N_DOM-1:0] dom_busy, dom_done, dom_on, dom_req, go_vec, dctl_we;
    logic [N_MOD-1:0] mctl_we;
    logic [31:0]      mctl_rd [N_MOD];
    logic [31:0]      mstat_rd[N_MOD];
    logic             go_hit;

    assign go_hit = bus_we && (bus_addr == OFF_GO);

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        assign go_vec[g]  = go_hit && bus_wdata[g];
        assign dctl_we[g] = bus_we && (bus_addr == OFF_DCTL + ADDR_W'(4 * g));
        pdc_domain_seq #(
            .XFER_CYCLES (XFER_CYCLES),
            .PWRUP_CYCLES(PWRUP_CYCLES)
        ) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_we(dctl_we[g]),
            .ctl_on(bus_wdata[0]),
            .go    (go_vec[g]),
            .busy  (dom_busy[g]),
            .done  (dom_done[g]),
            .dom_on(dom_on[g]),
            .req_on(dom_req[g])
        );
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        assign mctl_we[m] = bus_we && (bus_addr == OFF_MCTL + ADDR_W'(4 * m));
        pdc_module_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (mctl_we[m]),
            .wd_state(bus_wdata[ST_W-1:0]),
            .wd_lrst (bus_wdata[BIT_LRST]),
            .wd_force(bus_wdata[BIT_FORCE]),
            .apply   (dom_done[m / MODS_PER_DOM]),
            .ctl_rd  (mctl_rd[m]),
            .stat_rd (mstat_rd[m]),
            .clk_en  (mod_clk_en[m]),
            .lrst_n  (mod_rst_n[m])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_BUSY) bus_rdata = 32'(dom_busy);
        for (int i = 0; i < N_DOM; i++) begin
            if (bus_addr == OFF_DSTAT + ADDR_W'(4 * i)) bus_rdata = 32'(dom_on[i]);
            if (bus_addr == OFF_DCTL + ADDR_W'(4 * i))  bus_rdata = 32'(dom_req[i]);
        end
        for (int i = 0; i < N_MOD; i++) begin
            if (bus_addr == OFF_MSTAT + ADDR_W'(4 * i)) bus_rdata = mstat_rd[i];
            if (bus_addr == OFF_MCTL + ADDR_W'(4 * i))  bus_rdata = mctl_rd[i];
        end
    end

    // R4: a go bit for an idle domain always raises its busy flag next cycle
    p_go_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_hit && bus_wdata[0] && !dom_busy[0]) |=> dom_busy[0]);
endmodule

// File: tb/tb_pwr_domain_ctrl.sv
module tb_pwr_domain_ctrl;
    localparam int ND = 2, MPD = 2, NM = ND * MPD, XF = 8, PU = 4;

    logic        clk = 0, rst_n = 0, bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NM-1:0] mod_clk_en, mod_rst_n;

    pwr_domain_ctrl #(.N_DOM(ND), .MODS_PER_DOM(MPD), .XFER_CYCLES(XF),
                      .PWRUP_CYCLES(PU)) dut (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [5:0] e_st [NM];
    logic [5:0] e_nx [NM];
    logic       e_lr [NM];
    logic       e_on [ND];
    logic       e_rq [ND];
    logic       finished = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v, output int at);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_we = 1;
        @(posedge clk); #1 at = cyc;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; #1 v = bus_rdata;
    endtask

    task automatic wait_idle(int d, int start, output int dur);
        logic [31:0] v;
        dur = -1;
        for (int k = 0; k < 100; k++) begin
            rd(12'h128, v);
            if (!v[d]) begin dur = cyc - start; break; end
        end
    endtask

    task automatic check_mods(string req);
        logic [31:0] v;
        for (int m = 0; m < NM; m++) begin
            rd(12'h800 + 12'(4 * m), v);
            check(req, v, {19'd0, e_st[m] == 6'd3, 6'd0, e_st[m]});
            check("R8", 32'(mod_clk_en[m]), 32'(e_st[m] == 6'd3));
            check("R9", 32'(mod_rst_n[m]), 32'(e_st[m] == 6'd3 && e_lr[m]));
        end
    endtask

    task automatic run_go(int d, bit twice);
        int t0, t1, dur, texp;
        logic [31:0] v;
        texp = XF + ((!e_on[d] && e_rq[d]) ? PU : 0);
        wr(12'h120, 32'(1) << d, t0);
        rd(12'h128, v);
        check("R4 busy set", 32'(v[d]), 1);
        if (twice) wr(12'h120, 32'(1) << d, t1);
        wait_idle(d, t0, dur);
        check(twice ? "R7 duration" : (texp > XF ? "R6 duration" : "R4 duration"),
              32'(dur), 32'(texp));
        e_on[d] = e_rq[d];
        for (int m = d * MPD; m < (d + 1) * MPD; m++) e_st[m] = e_nx[m];
        rd(12'h200 + 12'(4 * d), v);
        check("R3 dom status", v, 32'(e_on[d]));
    endtask

    task automatic set_mod(int m, logic [5:0] st, logic lr, logic fr);
        int t;
        logic [31:0] v;
        wr(12'hA00 + 12'(4 * m), {fr, 22'h3FFFFF, lr, 2'b11, st}, t);
        e_nx[m] = st; e_lr[m] = lr;
        rd(12'hA00 + 12'(4 * m), v);
        check("R2 ctl readback", v, {fr, 22'd0, lr, 2'd0, st});
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int t;
        for (int m = 0; m < NM; m++) begin e_st[m] = 0; e_nx[m] = 0; e_lr[m] = 0; end
        for (int d = 0; d < ND; d++) begin e_on[d] = 0; e_rq[d] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(12'h128, v); check("R1 busy", v, 0);
        for (int d = 0; d < ND; d++) begin
            rd(12'h200 + 12'(4 * d), v); check("R1 dstat", v, 0);
            rd(12'h300 + 12'(4 * d), v); check("R1 dctl", v, 0);
        end
        for (int m = 0; m < NM; m++) begin
            rd(12'hA00 + 12'(4 * m), v); check("R1 mctl", v, 0);
        end
        check_mods("R1 mstat");

        // R10 unmapped and go reads
        rd(12'h120, v); check("R10 go read", v, 0);
        rd(12'h004, v); check("R10 unmapped", v, 0);
        rd(12'h80C + 12'(4 * NM), v); check("R10 past mods", v, 0);

        // R3 domain control readback, then power up both domains (R6)
        for (int d = 0; d < ND; d++) begin
            wr(12'h300 + 12'(4 * d), 32'hFFFF_FFFF, t);
            e_rq[d] = 1;
            rd(12'h300 + 12'(4 * d), v); check("R3 dctl readback", v, 1);
        end

        // Exhaustive sweep of state pairs per domain (R2, R5, R8, R9)
        for (int d = 0; d < ND; d++) begin
            for (int c = 0; c < 16; c++) begin
                for (int j = 0; j < MPD; j++)
                    set_mod(d * MPD + j, 6'((c >> (2 * j)) & 3), 1'((c + j + d) & 1), 1'(c & 1));
                check_mods("R2 staged only");
                run_go(d, 0);
                check_mods("R5 applied");
            end
        end

        // R9 reset bit followed live in enable state
        set_mod(0, 6'd3, 1'b1, 1'b0); run_go(0, 0);
        check("R9 live high", 32'(mod_rst_n[0]), 1);
        set_mod(0, 6'd3, 1'b0, 1'b0);
        check("R9 live low", 32'(mod_rst_n[0]), 0);
        check("R2 status kept", 32'(mod_clk_en[0]), 1);

        // R7 repeated go ignored
        run_go(1, 1);
        check_mods("R7 states");

        // R6 power down, then power up again
        wr(12'h300, 32'h0, t); e_rq[0] = 0;
        run_go(0, 0);
        wr(12'h300, 32'h1, t); e_rq[0] = 1;
        set_mod(1, 6'd2, 1'b1, 1'b1);
        run_go(0, 0);
        check_mods("R6 after power up");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule